// File: doc/BRIEF.md
# Serial Teletype Character Transmitter

This block turns one parallel character into a framed asynchronous serial stream for a teletype-style line. A character is taken from an active-low bus with a load strobe and inverted into an internal shift register. A transfer controller then pulses a start input, which drives the line low to form the start bit. After that the controller holds an enable level. While the enable is active, a divider makes one bit-time tick every 16 input clocks, and the register shifts once on each tick. The eight data bits leave least significant bit first, and two high stop bits follow them.

The block has no bit counter. On its first two shifts, ones are fed in behind the data, and zeros are fed after that. When the register holds only a single one in bit 0, the second stop bit has reached the output position. The block then raises a "character sent" flag for the controller. One more tick sends the last stop bit, clears the busy status and stops shifting until the next character is loaded.

Top module: `tty_char_tx`

## Requirements
- R1: Shifting happens only while the enable is high. The first shift comes on the 16th consecutive rising edge at which the enable is sampled high, and later shifts come every 16 edges after that. With the enable low, the line does not change.
- R2: The bus is active-low. Each data bit sent on the line is the inverse of the matching bus bit sampled at the accepted load.
- R3: When the start input is sampled high while busy, the line goes low and stays low until the first shift. If the enable rises on the next cycle, this start bit lasts exactly 16 clocks.
- R4: The data bits follow the start bit in least-significant-first order, each lasting 16 clocks. A 1 is sent as line high and a 0 as line low.
- R5: Two stop bits follow the eighth data bit, each high for 16 clocks.
- R6: The sent flag is high from the 9th shift up to the 10th shift, which is the first stop bit. It is low everywhere else, including straight after a load of any value.
- R7: The 10th shift clears busy. After it the line stays high and no further shift occurs, even if the enable stays high.
- R8: A load strobe that arrives while busy is ignored. The character in flight is sent unchanged.
- R9: Out of reset, the line is high and both busy and sent are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock, 16 per bit time |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe for the bus character |
| bus_data_n_i | input | 8 | Character from the bus, active-low |
| start_i | input | 1 | Start pulse from the controller; forces the start bit |
| tx_en_i | input | 1 | Shift enable level from the controller |
| line_o | output | 1 | Serial line, high is mark |
| sent_o | output | 1 | Character sent flag (first stop bit on the line) |
| busy_o | output | 1 | A character is loaded and not yet fully sent |

## Verification
The line and status outputs come from registers, so each result shows one edge after the edge that causes it. The start bit appears at the edge that samples the start pulse. Shift n appears 16·n edges after the enable is first sampled high. The bench counts falling edges from the cycle in which it raises the enable and samples each bit at its middle, 16·n+8 edges later. This leaves eight clocks of margin on each side of every bit boundary. The sent flag and busy are checked at the middles of data bit 7, stop bit 1 and stop bit 2, which places their transitions at the 9th and 10th shifts.

// File: rtl/tty_tx_pkg.sv
package tty_tx_pkg;
    localparam int DATA_W    = 8;
    localparam int STOP_BITS = 2;
    localparam int FILL_W    = $clog2(STOP_BITS + 1);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [FILL_W-1:0] fill;
        logic              line;
    } shifter_state_t;
endpackage

// File: rtl/tty_bit_divider.sv
module tty_bit_divider #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CNT_W = $clog2(DIV);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    assign wrap   = (cnt_q == CNT_W'(DIV - 1));
    assign tick_o = en_i && wrap;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i)     cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tty_frame_shifter.sv
module tty_frame_shifter
    import tty_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              start_i,
    input  logic              shift_i,
    output logic              line_o,
    output logic              marker_o
);
    shifter_state_t st_d, st_q;
    logic           fill_bit;

    assign fill_bit = (st_q.fill < FILL_W'(STOP_BITS));

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sr   = data_i;
            st_d.fill = '0;
        end else if (shift_i) begin
            st_d.line = st_q.sr[0];
            st_d.sr   = {fill_bit, st_q.sr[DATA_W-1:1]};
            if (fill_bit) st_d.fill = st_q.fill + 1'b1;
        end else if (start_i) begin
            st_d.line = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr   <= '0;
            st_q.fill <= FILL_W'(STOP_BITS);
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // Second stop bit sits alone in bit 0 once both fill ones are in.
    assign marker_o = (st_q.fill == FILL_W'(STOP_BITS)) &&
                      (st_q.sr == DATA_W'(1));
    assign line_o   = st_q.line;

    // R1: no tick, no load -> register contents hold
    p_hold_no_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !load_i) |=> $stable(st_q.sr));

    // R3: a start request alone drives the line low next cycle
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !shift_i && !load_i) |=> !line_o);

    // R5: never more than the configured number of fill ones
    p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= FILL_W'(STOP_BITS));
endmodule

// File: rtl/tty_char_tx.sv
module tty_char_tx
    import tty_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] bus_data_n_i,
    input  logic              start_i,
    input  logic              tx_en_i,
    output logic              line_o,
    output logic              sent_o,
    output logic              busy_o
);
    logic busy_d, busy_q;
    logic tick, accept, shift, start_ok, marker, done;

    assign accept   = load_i && !busy_q;
    assign shift    = tick && busy_q;
    assign start_ok = start_i && busy_q;
    assign done     = shift && marker;

    tty_bit_divider #(.DIV(CLKS_PER_BIT)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tx_en_i),
        .tick_o (tick)
    );

    tty_frame_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .data_i   (~bus_data_n_i),
        .start_i  (start_ok),
        .shift_i  (shift),
        .line_o   (line_o),
        .marker_o (marker)
    );

    always_comb begin
        busy_d = busy_q;
        if (accept)    busy_d = 1'b1;
        else if (done) busy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign sent_o = marker;
    assign busy_o = busy_q;

    // R6: flag only while the first stop bit (mark) is on the line
    p_sent_on_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sent_o |-> line_o);

    // R7/R9: whenever idle the line rests at mark
    p_idle_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> line_o);

    // R8: a load during a frame does not end the frame
    p_busy_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && busy_q && !done) |=> busy_q);
endmodule

// File: tb/tb_tty_char_tx.sv
module tb_tty_char_tx;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'h01, 8'hA5,
                                          8'h5A, 8'h80, 8'h7E, 8'h3C};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] bus_data_n_i = 8'hFF;
    logic       start_i = 1'b0;
    logic       tx_en_i = 1'b0;
    logic       line_o, sent_o, busy_o;
    int         errors = 0;
    int         checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tty_char_tx dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .bus_data_n_i (bus_data_n_i),
        .start_i      (start_i),
        .tx_en_i      (tx_en_i),
        .line_o       (line_o),
        .sent_o       (sent_o),
        .busy_o       (busy_o)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Acts as the transfer controller for one character.
    task automatic send_char(input logic [7:0] data, input bit inject,
                             input int hold, input int linger);
        @(negedge clk);
        load_i = 1'b1; bus_data_n_i = ~data;
        @(negedge clk);
        load_i = 1'b0; bus_data_n_i = 8'hFF;
        chk("R6 sent low after load", sent_o, 0);
        chk("R9 line mark before start", line_o, 1);
        chk("R8 busy after load", busy_o, 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk("R1 no shift while enable low", line_o, 0);
        end
        tx_en_i = 1'b1;
        repeat (8) @(negedge clk);
        chk("R3 start bit low", line_o, 0);
        for (int i = 0; i < 8; i++) begin
            if (inject && i == 3) begin
                load_i = 1'b1; bus_data_n_i = data;
                @(negedge clk);
                load_i = 1'b0; bus_data_n_i = 8'hFF;
                repeat (15) @(negedge clk);
            end else begin
                repeat (16) @(negedge clk);
            end
            chk($sformatf("R4 R2 data bit %0d of %02h", i, data),
                int'(line_o), int'(data[i]));
            if (inject) chk("R8 ignored load keeps data", int'(line_o), int'(data[i]));
        end
        chk("R6 sent low during bit 7", sent_o, 0);
        repeat (16) @(negedge clk);
        chk("R5 first stop bit", line_o, 1);
        chk("R6 sent high in first stop", sent_o, 1);
        chk("R7 busy in first stop", busy_o, 1);
        repeat (16) @(negedge clk);
        chk("R5 second stop bit", line_o, 1);
        chk("R6 sent low in second stop", sent_o, 0);
        chk("R7 busy cleared", busy_o, 0);
        if (linger > 0) begin
            repeat (linger) @(negedge clk);
            chk("R7 line mark with enable held", line_o, 1);
            chk("R7 still idle", busy_o, 0);
        end
        tx_en_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset line", line_o, 1);
        chk("R9 reset busy", busy_o, 0);
        chk("R9 reset sent", sent_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Start pulse while idle must not touch the line.
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        chk("R3 start ignored when idle", line_o, 1);

        for (int v = 0; v < NVEC; v++) send_char(VEC[v], 1'b0, 0, 0);
        for (int r = 0; r < 6; r++) send_char(8'($urandom), 1'b0, 0, 0);

        // Directed corner cases.
        send_char(8'h5A, 1'b1, 0, 0);   // R8 load while busy
        send_char(8'hC3, 1'b0, 40, 0);  // R1 enable held low after start
        send_char(8'h96, 1'b0, 0, 48);  // R7 enable left high after frame
        send_char(8'h01, 1'b0, 0, 0);   // R6 marker-like data value

        repeat (30) @(negedge clk);
        chk("R9 idle mark after frames", line_o, 1);
        summary();
        $finish;
    end
endmodule